// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block sits between a simple synchronous bus and a word-wide storage array and makes the array behave like a command-driven parallel NOR flash. Writes on the bus are not stored directly. The low byte of a write in the idle phase is decoded as a command, and later writes supply arguments, data or a confirm code. One sequencer tracks the active command and the write-cycle phase. A read is steered to one of four sources: the array, the 8-bit status byte, identifier data or query data.

The phase register has five states: `PH_IDLE` (command decode), `PH_ARG` (second write of a command: program data, erase confirm, lock code, query exit or buffered-write count), `PH_DATA` (counted buffered-write data), `PH_CONFIRM` (buffered-write confirm) and `PH_ERASE` (sector fill loop running). The transitions are as follows:
- `PH_IDLE` goes to `PH_ARG` on a program, lock, query or buffered-write code.
- `PH_IDLE` goes to `PH_ERASE` on an erase code when the array is writable.
- `PH_ERASE` goes to `PH_ARG` when the last word of the sector has been written.
- `PH_ARG` goes to `PH_DATA` after a buffered-write count.
- `PH_DATA` goes to `PH_CONFIRM` when the counter is found at zero.
- `PH_ARG` and `PH_CONFIRM` return to `PH_IDLE` on completion.
- Every unexpected write returns to `PH_IDLE` with the command cleared, which is read-array mode.

A read-only strap turns every storage write into an error flag in the status byte.

Top module: `nor_cmd_sequencer`

## Requirements
- R1: After reset, reads return array data, the phase is idle and the status byte is 0x00.
- R2: In the idle phase, codes 0x00, 0xF0, 0xFF and any unrecognised code return to read-array mode. Code 0x50 sets the status byte to 0x00 and also returns to read-array mode.
- R3: Codes 0x70 (status) and 0x90 (identifier) change only the read source. The next write is decoded again as a command.
- R4: Code 0x10 or 0x40 arms one program. The next write stores its data at its word address with byte lanes given by the access width, and sets status bit 7.
- R5: Code 0x20 fills the sector containing the address with all-ones, one word per cycle starting at the sector-aligned address. While the fill runs, `bus_wait` is high, status bit 7 reads 0 and bus writes are ignored. When the fill ends, bit 7 is set.
- R6: After an erase, a second write of 0xD0 completes it and reads stay on status. Any other value returns to read-array mode.
- R7: Code 0xE8 sets status bit 7. The next write gives a count masked to the device width. Exactly count+1 data writes are then stored before the confirm phase.
- R8: In the buffered-write confirm phase, 0xD0 completes the write and reads stay on status. Any other value returns to read-array mode, and the data already written is kept.
- R9: After code 0x60, a second write of 0xD0 or 0x01 sets status bit 7. Any other value returns to read-array mode.
- R10: While the command is 0x10, 0x20, 0x40, 0x60, 0x70 or 0xE8, a read returns the status byte copied into every device lane inside the access width. `bus_size` 0, 1 and 2 select 1, 2 and 4 bytes, and the higher bytes read 0.
- R11: After 0x90, word 0 returns the manufacturer code, word 1 returns the device code and other words return 0. After 0x98, words 0x10 to 0x13 return 0x51, 0x52, 0x59 and 0x01, and other words return 0. A write of 0xFF leaves query mode; any other write keeps query mode. Both results are copied into each device lane.
- R12: With `ro_strap` high, no storage write occurs. A program or buffered data write sets status bit 4 and bit 7. An erase sets bit 5 and bit 7 without running the fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ro_strap | input | 1 | Array is read-only |
| bus_wr | input | 1 | Bus write strobe |
| bus_addr | input | AW | Byte address |
| bus_wdata | input | 8*BUS_BYTES | Write data |
| bus_size | input | 2 | Access width code: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes |
| bus_rdata | output | 8*BUS_BYTES | Read data for the current address |
| bus_wait | output | 1 | Sector fill running; writes are ignored |
| mem_we | output | 1 | Storage write enable |
| mem_addr | output | AW-log2(BUS_BYTES) | Storage word address |
| mem_wdata | output | 8*BUS_BYTES | Storage write data |
| mem_be | output | BUS_BYTES | Storage byte enables |
| mem_rdata | input | 8*BUS_BYTES | Storage read data for `mem_addr` |

## Verification
The assertions assume the following about the inputs:
- `ro_strap` does not change while a sector fill runs.
- Storage read data follows `mem_addr` within the same cycle.
- The access width is at least the device width.

The stimulus sets the strap only between command sequences. It models the storage as a combinational-read word array, and it uses whole-word or device-width accesses. Reads are made only with `bus_wr` low. Writes are issued during a fill on purpose, to show that they are dropped.

// File: rtl/nfc_pkg.sv
package nfc_pkg;
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ARG,
        PH_DATA,
        PH_CONFIRM,
        PH_ERASE
    } phase_t;

    typedef enum logic [1:0] {
        RD_ARRAY,
        RD_STATUS,
        RD_IDENT,
        RD_QUERY
    } rdsel_t;

    localparam logic [7:0] OP_PROG_A   = 8'h10;
    localparam logic [7:0] OP_ERASE    = 8'h20;
    localparam logic [7:0] OP_ERASE_B  = 8'h28;
    localparam logic [7:0] OP_PROG_B   = 8'h40;
    localparam logic [7:0] OP_CLR_STAT = 8'h50;
    localparam logic [7:0] OP_LOCK     = 8'h60;
    localparam logic [7:0] OP_STATUS   = 8'h70;
    localparam logic [7:0] OP_IDENT    = 8'h90;
    localparam logic [7:0] OP_QUERY    = 8'h98;
    localparam logic [7:0] OP_BUFWR    = 8'hE8;
    localparam logic [7:0] OP_CONFIRM  = 8'hD0;
    localparam logic [7:0] OP_LOCK_ALT = 8'h01;
    localparam logic [7:0] OP_ARRAY    = 8'hFF;
endpackage

// File: rtl/nfc_erase_walker.sv
module nfc_erase_walker #(
    parameter int WA         = 6,
    parameter int SECT_WORDS = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [WA-1:0] base,
    output logic          busy,
    output logic          done,
    output logic [WA-1:0] addr
);
    localparam int OFS_W = $clog2(SECT_WORDS);

    logic [OFS_W-1:0] ofs_q;
    logic [WA-1:0]    base_q;
    logic             busy_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            ofs_q  <= '0;
            base_q <= '0;
        end else if (start) begin
            busy_q <= 1'b1;
            ofs_q  <= '0;
            base_q <= base;
        end else if (busy_q) begin
            if (done) busy_q <= 1'b0;
            else      ofs_q  <= ofs_q + 1'b1;
        end
    end

    assign busy = busy_q;
    assign done = busy_q && (ofs_q == OFS_W'(SECT_WORDS - 1));
    assign addr = {base_q[WA-1:OFS_W], ofs_q};

    // R5: the fill visits consecutive words of one sector
    p_walk_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> (addr == $past(addr) + WA'(1)));
endmodule

// File: rtl/nfc_read_mux.sv
module nfc_read_mux
    import nfc_pkg::*;
#(
    parameter int          BUS_BYTES = 4,
    parameter int          DEV_BYTES = 1,
    parameter logic [15:0] MFR_CODE  = 16'h0089,
    parameter logic [15:0] DEV_CODE  = 16'h0018
) (
    input  rdsel_t                   sel,
    input  logic [7:0]               status,
    input  logic [7:0]               idx,
    input  logic [1:0]               size,
    input  logic [BUS_BYTES*8-1:0]   array_data,
    output logic [BUS_BYTES*8-1:0]   rdata
);
    localparam int DW    = DEV_BYTES * 8;
    localparam int LANES = BUS_BYTES / DEV_BYTES;

    logic [DW-1:0]          dev_val;
    logic [BUS_BYTES*8-1:0] rep;
    int                     nbytes;

    always_comb begin
        nbytes  = 1 << size;
        dev_val = '0;
        unique case (sel)
            RD_STATUS: dev_val = DW'(status);
            RD_IDENT: begin
                if (idx == 8'h00)      dev_val = MFR_CODE[DW-1:0];
                else if (idx == 8'h01) dev_val = DEV_CODE[DW-1:0];
            end
            RD_QUERY: begin
                case (idx)
                    8'h10:   dev_val = DW'(8'h51);
                    8'h11:   dev_val = DW'(8'h52);
                    8'h12:   dev_val = DW'(8'h59);
                    8'h13:   dev_val = DW'(8'h01);
                    default: dev_val = '0;
                endcase
            end
            RD_ARRAY: dev_val = '0;
        endcase
    end

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign rep[k*DW +: DW] = ((k * DEV_BYTES) < nbytes) ? dev_val : '0;
    end

    assign rdata = (sel == RD_ARRAY) ? array_data : rep;
endmodule

// File: rtl/nor_cmd_sequencer.sv
module nor_cmd_sequencer
    import nfc_pkg::*;
#(
    parameter int          AW         = 8,
    parameter int          BUS_BYTES  = 4,
    parameter int          DEV_BYTES  = 1,
    parameter int          SECT_WORDS = 16,
    parameter logic [15:0] MFR_CODE   = 16'h0089,
    parameter logic [15:0] DEV_CODE   = 16'h0018
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          ro_strap,
    input  logic                          bus_wr,
    input  logic [AW-1:0]                 bus_addr,
    input  logic [BUS_BYTES*8-1:0]        bus_wdata,
    input  logic [1:0]                    bus_size,
    output logic [BUS_BYTES*8-1:0]        bus_rdata,
    output logic                          bus_wait,
    output logic                          mem_we,
    output logic [AW-$clog2(BUS_BYTES)-1:0] mem_addr,
    output logic [BUS_BYTES*8-1:0]        mem_wdata,
    output logic [BUS_BYTES-1:0]          mem_be,
    input  logic [BUS_BYTES*8-1:0]        mem_rdata
);
    localparam int LB = $clog2(BUS_BYTES);
    localparam int WA = AW - LB;
    localparam int CW = DEV_BYTES * 8;

    phase_t          phase_q, phase_n;
    logic [7:0]      cmd_q, cmd_n;
    logic [7:0]      stat_q, stat_n;
    logic [CW-1:0]   cnt_q, cnt_n;
    logic            erase_go, store;
    logic            walk_busy, walk_done;
    logic [WA-1:0]   walk_addr;
    logic [WA-1:0]   word;
    logic [7:0]      code;
    logic            acc;
    rdsel_t          rsel;

    assign word = bus_addr[AW-1:LB];
    assign code = bus_wdata[7:0];
    assign acc  = bus_wr && !walk_busy;

    nfc_erase_walker #(.WA(WA), .SECT_WORDS(SECT_WORDS)) u_walk (
        .clk(clk), .rst_n(rst_n), .start(erase_go), .base(word),
        .busy(walk_busy), .done(walk_done), .addr(walk_addr)
    );

    // next-state decode
    always_comb begin
        phase_n  = phase_q;
        cmd_n    = cmd_q;
        stat_n   = stat_q;
        cnt_n    = cnt_q;
        erase_go = 1'b0;
        store    = 1'b0;
        unique case (phase_q)
            PH_ERASE: begin
                if (walk_done) begin
                    phase_n   = PH_ARG;
                    stat_n[7] = 1'b1;
                end
            end
            PH_IDLE: if (acc) begin
                case (code)
                    OP_PROG_A, OP_PROG_B, OP_LOCK, OP_QUERY: begin
                        phase_n = PH_ARG;
                        cmd_n   = code;
                    end
                    OP_ERASE: begin
                        cmd_n = code;
                        if (ro_strap) begin
                            stat_n  = stat_q | 8'hA0;
                            phase_n = PH_ARG;
                        end else begin
                            stat_n[7] = 1'b0;
                            phase_n   = PH_ERASE;
                            erase_go  = 1'b1;
                        end
                    end
                    OP_CLR_STAT: begin
                        stat_n = 8'h00;
                        cmd_n  = 8'h00;
                    end
                    OP_STATUS, OP_IDENT: cmd_n = code;
                    OP_BUFWR: begin
                        stat_n[7] = 1'b1;
                        phase_n   = PH_ARG;
                        cmd_n     = code;
                    end
                    default: cmd_n = 8'h00;
                endcase
            end
            PH_ARG: if (acc) begin
                phase_n = PH_IDLE;
                case (cmd_q)
                    OP_PROG_A, OP_PROG_B: begin
                        store = 1'b1;
                        stat_n = stat_q | (ro_strap ? 8'h90 : 8'h80);
                    end
                    OP_ERASE, OP_ERASE_B: begin
                        if (code == OP_CONFIRM) stat_n[7] = 1'b1;
                        else                    cmd_n = 8'h00;
                    end
                    OP_LOCK: begin
                        if (code == OP_CONFIRM || code == OP_LOCK_ALT) stat_n[7] = 1'b1;
                        else                                           cmd_n = 8'h00;
                    end
                    OP_QUERY: begin
                        if (code == OP_ARRAY) cmd_n = 8'h00;
                        else                  phase_n = PH_ARG;
                    end
                    OP_BUFWR: begin
                        cnt_n   = bus_wdata[CW-1:0];
                        phase_n = PH_DATA;
                    end
                    default: cmd_n = 8'h00;
                endcase
            end
            PH_DATA: if (acc) begin
                store  = 1'b1;
                stat_n = stat_q | (ro_strap ? 8'h90 : 8'h80);
                cnt_n  = cnt_q - 1'b1;
                if (cnt_q == '0) phase_n = PH_CONFIRM;
            end
            PH_CONFIRM: if (acc) begin
                phase_n = PH_IDLE;
                if (code == OP_CONFIRM) stat_n[7] = 1'b1;
                else                    cmd_n = 8'h00;
            end
            default: begin
                phase_n = PH_IDLE;
                cmd_n   = 8'h00;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cmd_q   <= 8'h00;
            stat_q  <= 8'h00;
            cnt_q   <= '0;
        end else begin
            phase_q <= phase_n;
            cmd_q   <= cmd_n;
            stat_q  <= stat_n;
            cnt_q   <= cnt_n;
        end
    end

    // outputs
    always_comb begin
        int off, nb;
        off = int'(bus_addr[LB-1:0]);
        nb  = 1 << bus_size;
        for (int k = 0; k < BUS_BYTES; k++) begin
            mem_be[k] = walk_busy || ((k >= off) && (k < off + nb));
        end
        mem_we    = walk_busy || (store && !ro_strap);
        mem_addr  = walk_busy ? walk_addr : word;
        mem_wdata = walk_busy ? '1 : bus_wdata;
        bus_wait  = walk_busy;
        case (cmd_q)
            OP_PROG_A, OP_ERASE, OP_ERASE_B, OP_PROG_B,
            OP_CLR_STAT, OP_LOCK, OP_STATUS, OP_BUFWR: rsel = RD_STATUS;
            OP_IDENT: rsel = RD_IDENT;
            OP_QUERY: rsel = RD_QUERY;
            default:  rsel = RD_ARRAY;
        endcase
    end

    nfc_read_mux #(.BUS_BYTES(BUS_BYTES), .DEV_BYTES(DEV_BYTES),
                   .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)) u_rmux (
        .sel(rsel), .status(stat_q), .idx(8'(word)), .size(bus_size),
        .array_data(mem_rdata), .rdata(bus_rdata)
    );

    // R12: a read-only array never sees a storage write
    p_ro_no_store_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (ro_strap && !bus_wait) |-> !mem_we);
    // R5: ready bit reads low while the fill runs
    p_wait_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wait |-> !bus_rdata[7]);
    // R5: ready bit is set once the fill ends
    p_fill_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_wait) |-> stat_q[7]);
    // R2: clear-status empties the status byte
    p_clear_stat_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && phase_q == PH_IDLE && code == OP_CLR_STAT) |=> (stat_q == 8'h00));
    // R3: mode-only codes leave the phase idle
    p_mode_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && phase_q == PH_IDLE && (code == OP_STATUS || code == OP_IDENT))
        |=> (phase_q == PH_IDLE));
endmodule

// File: tb/sim_nor_cmd_sequencer.sv
module sim_nor_cmd_sequencer;
    localparam int CLK_NS = 10;
    localparam int NW     = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ro_strap = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [1:0]  bus_size = 2'd2;
    logic [31:0] bus_rdata;
    logic        bus_wait;
    logic        mem_we;
    logic [5:0]  mem_addr;
    logic [31:0] mem_wdata;
    logic [3:0]  mem_be;
    logic [31:0] mem_rdata;

    logic [31:0] mem [NW];
    logic [31:0] ref_mem [NW];
    logic [31:0] exp_q [$];
    string       tag_q [$];
    logic        rd_go = 1'b0;
    int          n_cmp = 0;
    int          n_bad = 0;
    bit          done_flag = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    nor_cmd_sequencer u0 (
        .clk(clk), .rst_n(rst_n), .ro_strap(ro_strap), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_size(bus_size),
        .bus_rdata(bus_rdata), .bus_wait(bus_wait), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be),
        .mem_rdata(mem_rdata)
    );

    assign mem_rdata = mem[mem_addr];
    always @(posedge clk) begin
        if (mem_we) begin
            for (int b = 0; b < 4; b++)
                if (mem_be[b]) mem[mem_addr][8*b +: 8] <= mem_wdata[8*b +: 8];
        end
    end

    // monitor: compares read data against the queued expectation
    always @(negedge clk) begin
        #(CLK_NS/4);
        if (rd_go && exp_q.size() > 0) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_cmp++;
            if (bus_rdata !== e) begin
                n_bad++;
                $display("FAIL %s: rdata actual %h expected %h", t, bus_rdata, e);
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_size = 2'd2;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [1:0] sz,
                      input logic [31:0] e, input string t);
        @(negedge clk);
        bus_addr = a; bus_size = sz;
        exp_q.push_back(e);
        tag_q.push_back(t);
        rd_go = 1'b1;
        @(negedge clk);
        rd_go = 1'b0;
    endtask

    task automatic chk_bit(input logic act, input logic e, input string t);
        n_cmp++;
        if (act !== e) begin
            n_bad++;
            $display("FAIL %s: bit actual %b expected %b", t, act, e);
        end
    endtask

    task automatic wait_ready();
        while (bus_wait) @(negedge clk);
    endtask

    initial begin
        #(CLK_NS * 100000);
        if (!done_flag) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NW; i++) begin
            mem[i]     = 32'hC0DE0000 + i;
            ref_mem[i] = 32'hC0DE0000 + i;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(8'h04, 2'd2, ref_mem[1], "R1");
        chk_bit(bus_wait, 1'b0, "R1");
        wr(8'h00, 32'h70);
        rd(8'h00, 2'd0, 32'h0, "R1");

        // R4 program, R10 replication across widths
        wr(8'h08, 32'h40);
        wr(8'h08, 32'h12345678);
        ref_mem[2] = 32'h12345678;
        rd(8'h08, 2'd2, 32'h80808080, "R10");
        rd(8'h08, 2'd1, 32'h00008080, "R10");
        rd(8'h08, 2'd0, 32'h00000080, "R10");
        wr(8'h00, 32'hFF);
        rd(8'h08, 2'd2, 32'h12345678, "R4");

        // R11 identifier and query
        wr(8'h00, 32'h90);
        rd(8'h00, 2'd2, 32'h89898989, "R11");
        rd(8'h04, 2'd2, 32'h18181818, "R11");
        rd(8'h08, 2'd2, 32'h0, "R11");
        // R3: identifier code does not advance phase, 0x70 decoded as command
        wr(8'h00, 32'h70);
        rd(8'h00, 2'd0, 32'h80, "R3");
        wr(8'h00, 32'h98);
        rd(8'h40, 2'd2, 32'h51515151, "R11");
        wr(8'h00, 32'h00);
        rd(8'h44, 2'd2, 32'h52525252, "R11");
        rd(8'h4C, 2'd2, 32'h01010101, "R11");
        wr(8'h00, 32'hFF);
        rd(8'h44, 2'd2, ref_mem[17], "R11");

        // R5 sector fill
        wr(8'h24, 32'h20);
        chk_bit(bus_wait, 1'b1, "R5");
        rd(8'h00, 2'd0, 32'h00, "R5");
        wr(8'h00, 32'h50);
        wait_ready();
        for (int i = 0; i < 16; i++) ref_mem[i] = 32'hFFFFFFFF;
        rd(8'h00, 2'd0, 32'h80, "R5");
        // R6 confirm keeps status
        wr(8'h00, 32'hD0);
        rd(8'h00, 2'd0, 32'h80, "R6");
        wr(8'h00, 32'hFF);
        rd(8'h00, 2'd2, ref_mem[0], "R5");
        rd(8'h3C, 2'd2, ref_mem[15], "R5");
        rd(8'h40, 2'd2, ref_mem[16], "R5");

        // R2 clear status, unknown codes
        wr(8'h00, 32'h50);
        rd(8'h40, 2'd2, ref_mem[16], "R2");
        wr(8'h00, 32'h70);
        rd(8'h00, 2'd0, 32'h00, "R2");
        wr(8'h00, 32'h33);
        rd(8'h48, 2'd2, ref_mem[18], "R2");
        wr(8'h00, 32'h70);
        wr(8'h00, 32'hF0);
        rd(8'h4C, 2'd2, ref_mem[19], "R2");

        // R6 bad second write after erase
        wr(8'h84, 32'h20);
        wait_ready();
        for (int i = 32; i < 48; i++) ref_mem[i] = 32'hFFFFFFFF;
        wr(8'h84, 32'h33);
        rd(8'hBC, 2'd2, ref_mem[47], "R6");
        rd(8'hC0, 2'd2, ref_mem[48], "R6");

        // R7 buffered write with masked count 0x0302 -> 2 -> three words
        wr(8'h00, 32'h50);
        wr(8'hC0, 32'hE8);
        rd(8'hC0, 2'd0, 32'h80, "R7");
        wr(8'hC0, 32'h00000302);
        wr(8'hC0, 32'hAAAA0001);
        wr(8'hC4, 32'hAAAA0002);
        wr(8'hC8, 32'hAAAA0003);
        ref_mem[48] = 32'hAAAA0001;
        ref_mem[49] = 32'hAAAA0002;
        ref_mem[50] = 32'hAAAA0003;
        wr(8'hCC, 32'hD0);
        rd(8'hCC, 2'd0, 32'h80, "R8");
        wr(8'hCC, 32'hFF);
        rd(8'hC0, 2'd2, ref_mem[48], "R7");
        rd(8'hC8, 2'd2, ref_mem[50], "R7");
        rd(8'hCC, 2'd2, ref_mem[51], "R7");

        // R8 bad confirm
        wr(8'hD0, 32'hE8);
        wr(8'hD0, 32'h0);
        wr(8'hD0, 32'hBBBB0001);
        ref_mem[52] = 32'hBBBB0001;
        wr(8'hD4, 32'h77);
        rd(8'hD0, 2'd2, ref_mem[52], "R8");
        rd(8'hD4, 2'd2, ref_mem[53], "R8");

        // R9 lock setup
        wr(8'h00, 32'h50);
        wr(8'h00, 32'h60);
        wr(8'h00, 32'h01);
        rd(8'h00, 2'd0, 32'h80, "R9");
        wr(8'h00, 32'h60);
        wr(8'h00, 32'h55);
        rd(8'hF0, 2'd2, ref_mem[60], "R9");

        // R12 read-only strap
        ro_strap = 1'b1;
        wr(8'h00, 32'h50);
        wr(8'hF4, 32'h40);
        wr(8'hF4, 32'hDEADBEEF);
        rd(8'hF4, 2'd0, 32'h90, "R12");
        wr(8'h00, 32'h50);
        wr(8'h40, 32'h20);
        chk_bit(bus_wait, 1'b0, "R12");
        rd(8'h40, 2'd0, 32'hA0, "R12");
        wr(8'h00, 32'hFF);
        rd(8'hF4, 2'd2, ref_mem[61], "R12");
        rd(8'h40, 2'd2, ref_mem[16], "R12");
        wr(8'h00, 32'h50);
        wr(8'hF8, 32'hE8);
        wr(8'hF8, 32'h0);
        wr(8'hF8, 32'h12121212);
        rd(8'hF8, 2'd0, 32'h90, "R12");
        wr(8'hF8, 32'hD0);
        wr(8'h00, 32'hFF);
        rd(8'hF8, 2'd2, ref_mem[62], "R12");
        ro_strap = 1'b0;

        repeat (3) @(negedge clk);
        done_flag = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule